// File: doc/BRIEF.md
# Synchronous Clock Stop Gating Controller

This block produces four groups of derived clocks from one fast source clock: a processor group, a memory group that runs in phase with the processor group, a peripheral-bus group at half the processor rate, and a fixed-rate group. All group clocks come from one shared phase counter. Two asynchronous active-low control pins stop the groups. The processor-stop pin parks only the processor group. The power-down pin parks every group. Leaving power-down also waits a programmable number of fast-clock cycles, which stands in for the oscillator settling time, before the clocks restart.

Each group has a small state machine. It stops the group only at a period boundary, so the last pulse is always full width and the output then stays low. It restarts the group at a period boundary, so the first pulse is also full width. A configuration strap is captured once, on the first clock after reset. With the strap at 0 the two control pins act as stop inputs. With the strap at 1 the stop functions are off and two extra clock outputs (one peripheral-rate, one fixed-rate) toggle in their place. A per-group status vector shows which groups are running.

Top module: `clk_stop_gate`

## Requirements
- R1: While reset is asserted, every clock output is low and `grp_run` reads 4'b1111 (bit 0 processor, bit 1 memory, bit 2 peripheral, bit 3 fixed).
- R2: `mode_strap` is captured on the first rising clock edge after reset is released. Later changes have no effect until the next reset.
- R3: With a captured strap of 1, both control pins are ignored: all groups keep running, `pci_x` toggles at the peripheral rate and `ref_x` toggles at the fixed rate. With a captured strap of 0, `pci_x` and `ref_x` stay low.
- R4: The processor and memory clocks have a period of 2 fast cycles and are identical while both run. The peripheral period is 4 fast cycles and the fixed period is 8 fast cycles. All bits of one group's output vector are equal.
- R5: After `cpu_stop_n` falls, the processor group still produces at least one pulse within 4 fast cycles. It is low from the 7th fast cycle on, and the other groups keep running.
- R6: After `cpu_stop_n` rises, the first processor pulse appears between the 4th and 8th fast cycle.
- R7: Every high pulse on every group is exactly half its period wide. No shortened pulse appears when a group stops or starts.
- R8: While `pwr_dn_n` is low, all four groups stop low within 16 fast cycles and `grp_run` reads 0. The processor group stays stopped after power-down ends while `cpu_stop_n` is still low.
- R9: After `pwr_dn_n` rises, every group output stays low for at least RESTART_CYC+2 fast cycles. All groups run again by RESTART_CYC+24 fast cycles.
- R10: A `cpu_stop_n` low pulse one fast cycle long does not interrupt the processor clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_strap | input | 1 | Pin-function strap, captured after reset |
| cpu_stop_n | input | 1 | Asynchronous active-low processor-group stop |
| pwr_dn_n | input | 1 | Asynchronous active-low power-down |
| cpu_clk | output | N_CPU | Processor group clocks |
| mem_clk | output | N_MEM | Memory group clocks |
| pci_clk | output | N_PCI | Peripheral-bus group clocks |
| fix_clk | output | N_FIX | Fixed-rate group clocks |
| pci_x | output | 1 | Extra peripheral-rate clock when strap is 1 |
| ref_x | output | 1 | Extra fixed-rate clock when strap is 1 |
| grp_run | output | 4 | Per-group running status |

## Verification
The assertions rely on the strap being steady across the first clock after reset. They also rely on the control pins being free of pulses shorter than the source clock's resolution, because a pulse seen by only one synchroniser stage has no defined effect. The bench changes every input one nanosecond after a rising edge, so each pin level is seen by whole clock edges. It holds the stop and power-down levels well beyond the stop latency, and the single-cycle glitch of R10 is the only deliberately short pulse.

// File: rtl/cg_pkg.sv
package cg_pkg;
  typedef enum logic [1:0] {
    GS_RUN    = 2'd0,
    GS_WSTOP  = 2'd1,
    GS_OFF    = 2'd2,
    GS_WSTART = 2'd3
  } gate_st_e;

  localparam int NGRP   = 4;
  localparam int GI_CPU = 0;
  localparam int GI_MEM = 1;
  localparam int GI_PCI = 2;
  localparam int GI_FIX = 3;
endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int           W       = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/cg_restart_timer.sv
module cg_restart_timer #(
  parameter int CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_i,
  output logic hold_o
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (pd_i) cnt_d = CW'(CYC);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hold_o = pd_i | (cnt_q != '0);

  // R9
  restart_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_i) |-> hold_o);
endmodule

// File: rtl/cg_group_gate.sv
module cg_group_gate
  import cg_pkg::*;
#(
  parameter int LOG2 = 1,
  parameter int LAT  = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stop_i,
  input  logic [LOG2-1:0] ph_i,
  output logic            clk_o,
  output logic            run_o
);
  localparam int            LW   = $clog2(LAT + 2);
  localparam logic [LOG2-1:0] HALF = LOG2'(1) << (LOG2 - 1);

  gate_st_e        st_q, st_d;
  logic [LW-1:0]   lat_q, lat_d;
  logic            clk_q, clk_d;
  logic            boundary, lat_done, en_d;
  logic [LOG2-1:0] ph_nx;

  assign boundary = &ph_i;
  assign lat_done = (lat_q >= LW'(LAT));
  assign ph_nx    = ph_i + 1'b1;

  always_comb begin
    st_d  = st_q;
    lat_d = lat_done ? lat_q : lat_q + 1'b1;
    case (st_q)
      GS_RUN: begin
        if (stop_i) begin
          st_d  = GS_WSTOP;
          lat_d = '0;
        end
      end
      GS_WSTOP: begin
        if (!stop_i)                  st_d = GS_RUN;
        else if (lat_done && boundary) st_d = GS_OFF;
      end
      GS_OFF: begin
        if (!stop_i) begin
          st_d  = GS_WSTART;
          lat_d = '0;
        end
      end
      GS_WSTART: begin
        if (stop_i)                    st_d = GS_OFF;
        else if (lat_done && boundary) st_d = GS_RUN;
      end
      default: st_d = GS_OFF;
    endcase
    en_d  = (st_d == GS_RUN) || (st_d == GS_WSTOP);
    clk_d = en_d & ~ph_nx[LOG2-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= GS_RUN;
      lat_q <= '0;
      clk_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      lat_q <= lat_d;
      clk_q <= clk_d;
    end
  end

  assign clk_o = clk_q;
  assign run_o = (st_q == GS_RUN) || (st_q == GS_WSTOP);

  // R7
  full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_q) |-> (ph_i == '0));
  // R7
  full_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_q) |-> (ph_i == HALF));
  // R8
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == GS_OFF) |-> !clk_q);
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
  import cg_pkg::*;
#(
  parameter int N_CPU       = 4,
  parameter int N_MEM       = 12,
  parameter int N_PCI       = 6,
  parameter int N_FIX       = 3,
  parameter int CPU_LOG2    = 1,
  parameter int PCI_LOG2    = 2,
  parameter int FIX_LOG2    = 3,
  parameter int STOP_LAT    = 1,
  parameter int RESTART_CYC = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_strap,
  input  logic             cpu_stop_n,
  input  logic             pwr_dn_n,
  output logic [N_CPU-1:0] cpu_clk,
  output logic [N_MEM-1:0] mem_clk,
  output logic [N_PCI-1:0] pci_clk,
  output logic [N_FIX-1:0] fix_clk,
  output logic             pci_x,
  output logic             ref_x,
  output logic [NGRP-1:0]  grp_run
);
  localparam int CW_A = (CPU_LOG2 > PCI_LOG2) ? CPU_LOG2 : PCI_LOG2;
  localparam int CW   = (CW_A > FIX_LOG2) ? CW_A : FIX_LOG2;

  logic            strap_done, mode_q;
  logic [1:0]      pin_s;
  logic            cpu_req, pd_req, pd_hold;
  logic [CW-1:0]   cnt_q;
  logic [NGRP-1:0] stop_vec, g_clk;

  // strap capture: clock enable is the not-yet-captured flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_done <= 1'b0;
      mode_q     <= 1'b1;
    end else if (!strap_done) begin
      strap_done <= 1'b1;
      mode_q     <= mode_strap;
    end
  end

  cg_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({cpu_stop_n, pwr_dn_n}),
    .q    (pin_s)
  );

  assign cpu_req = ~pin_s[1] & ~mode_q;
  assign pd_req  = ~pin_s[0] & ~mode_q;

  cg_restart_timer #(.CYC(RESTART_CYC)) u_rst_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .pd_i  (pd_req),
    .hold_o(pd_hold)
  );

  // shared phase counter; reset to all ones so the first edge is a boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    stop_vec         = {NGRP{pd_hold}};
    stop_vec[GI_CPU] = cpu_req | pd_hold;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int GL = (g == GI_PCI) ? PCI_LOG2 :
                        (g == GI_FIX) ? FIX_LOG2 : CPU_LOG2;
    cg_group_gate #(.LOG2(GL), .LAT(STOP_LAT)) u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .stop_i(stop_vec[g]),
      .ph_i  (cnt_q[GL-1:0]),
      .clk_o (g_clk[g]),
      .run_o (grp_run[g])
    );
  end

  assign cpu_clk = {N_CPU{g_clk[GI_CPU]}};
  assign mem_clk = {N_MEM{g_clk[GI_MEM]}};
  assign pci_clk = {N_PCI{g_clk[GI_PCI]}};
  assign fix_clk = {N_FIX{g_clk[GI_FIX]}};
  assign pci_x   = mode_q & g_clk[GI_PCI];
  assign ref_x   = mode_q & g_clk[GI_FIX];

  // R2
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strap_done |=> $stable(mode_q));
  // R3
  strap_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> (&grp_run));
  // R4
  mem_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_run[GI_CPU] && grp_run[GI_MEM]) |-> (g_clk[GI_CPU] == g_clk[GI_MEM]));
endmodule

// File: tb/sim_clk_stop_gate.sv
`timescale 1ns/1ps
module sim_clk_stop_gate;
  localparam int RC = 40;

  logic clk = 1'b0;
  logic rst_n, mode_strap, cpu_stop_n, pwr_dn_n;
  logic [3:0]  cpu_clk;
  logic [11:0] mem_clk;
  logic [5:0]  pci_clk;
  logic [2:0]  fix_clk;
  logic pci_x, ref_x;
  logic [3:0]  grp_run;

  int checks = 0;
  int fails  = 0;
  int pw_err = 0;
  int pw_cnt = 0;
  int vec_err = 0;
  int hl [4];
  bit done = 0;

  // cpu_stop_n, pwr_dn_n, expected grp_run
  localparam logic [5:0] VEC [8] = '{
    6'b11_1111, 6'b01_1110, 6'b00_0000, 6'b10_0000,
    6'b11_1111, 6'b00_0000, 6'b01_1110, 6'b11_1111
  };
  localparam int EXPW [4] = '{1, 1, 2, 4};

  always #2 clk = ~clk;

  clk_stop_gate #(.RESTART_CYC(RC)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap),
    .cpu_stop_n(cpu_stop_n), .pwr_dn_n(pwr_dn_n),
    .cpu_clk(cpu_clk), .mem_clk(mem_clk), .pci_clk(pci_clk), .fix_clk(fix_clk),
    .pci_x(pci_x), .ref_x(ref_x), .grp_run(grp_run)
  );

  // pulse-width (R7) and vector consistency (R4) monitor
  always @(negedge clk) begin
    logic [3:0] lvl;
    lvl = {fix_clk[0], pci_clk[0], mem_clk[0], cpu_clk[0]};
    if (!rst_n) begin
      for (int g = 0; g < 4; g++) hl[g] = 0;
    end else begin
      for (int g = 0; g < 4; g++) begin
        if (lvl[g]) hl[g]++;
        else begin
          if (hl[g] != 0) begin
            pw_cnt++;
            if (hl[g] != EXPW[g]) pw_err++;
          end
          hl[g] = 0;
        end
      end
      if ((cpu_clk != '0 && cpu_clk != '1) || (mem_clk != '0 && mem_clk != '1) ||
          (pci_clk != '0 && pci_clk != '1) || (fix_clk != '0 && fix_clk != '1))
        vec_err++;
      if (grp_run[0] && grp_run[1] && (cpu_clk[0] != mem_clk[0])) vec_err++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sample_n(input int n, output int r_cpu, output int r_mem,
                          output int r_pci, output int r_fix, output int r_px,
                          output int r_rx, output int hi_any);
    logic [5:0] prev, cur;
    r_cpu = 0; r_mem = 0; r_pci = 0; r_fix = 0; r_px = 0; r_rx = 0; hi_any = 0;
    @(negedge clk);
    prev = {ref_x, pci_x, fix_clk[0], pci_clk[0], mem_clk[0], cpu_clk[0]};
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cur = {ref_x, pci_x, fix_clk[0], pci_clk[0], mem_clk[0], cpu_clk[0]};
      if (cur[0] && !prev[0]) r_cpu++;
      if (cur[1] && !prev[1]) r_mem++;
      if (cur[2] && !prev[2]) r_pci++;
      if (cur[3] && !prev[3]) r_fix++;
      if (cur[4] && !prev[4]) r_px++;
      if (cur[5] && !prev[5]) r_rx++;
      if (cur[3:0] != 4'b0) hi_any++;
      prev = cur;
    end
  endtask

  task automatic do_reset(input logic strap);
    @(posedge clk); #1;
    rst_n = 1'b0;
    mode_strap = strap;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int rc, rm, rp, rf, rx, rr, ha, first, late;
    bit seen;
    rst_n = 1'b0; mode_strap = 1'b0; cpu_stop_n = 1'b1; pwr_dn_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({cpu_clk, mem_clk, pci_clk, fix_clk, pci_x, ref_x} == '0, "R1 clocks", 1, 0);
    chk(grp_run == 4'hF, "R1 grp_run", grp_run, 15);
    @(posedge clk); #1 rst_n = 1'b1;

    // table walk, strap 0
    for (int v = 0; v < 8; v++) begin
      cpu_stop_n = VEC[v][5];
      pwr_dn_n   = VEC[v][4];
      wait_edges(80);
      chk(grp_run == VEC[v][3:0], "R8 table grp_run", grp_run, VEC[v][3:0]);
      sample_n(32, rc, rm, rp, rf, rx, rr, ha);
      chk(rc == (VEC[v][0] ? 16 : 0), "R4 table cpu rises", rc, VEC[v][0] ? 16 : 0);
      chk(rm == (VEC[v][1] ? 16 : 0), "R4 table mem rises", rm, VEC[v][1] ? 16 : 0);
      chk(rp == (VEC[v][2] ? 8 : 0),  "R4 table pci rises", rp, VEC[v][2] ? 8 : 0);
      chk(rf == (VEC[v][3] ? 4 : 0),  "R4 table fix rises", rf, VEC[v][3] ? 4 : 0);
      chk(rx == 0 && rr == 0, "R3 extra outputs low in strap 0", rx + rr, 0);
    end

    // R5 stop latency
    @(posedge clk); #1 cpu_stop_n = 1'b0;
    seen = 0; late = 0;
    for (int k = 1; k <= 22; k++) begin
      @(negedge clk);
      if (k <= 4 && cpu_clk[0]) seen = 1;
      if (k >= 7 && cpu_clk != '0) late++;
    end
    chk(seen, "R5 pulse before stop", seen, 1);
    chk(late == 0, "R5 stopped low", late, 0);
    chk(grp_run == 4'b1110, "R5 others run", grp_run, 14);

    // R6 restart latency
    @(posedge clk); #1 cpu_stop_n = 1'b1;
    first = 0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (first == 0 && cpu_clk[0]) first = k;
    end
    chk(first >= 4 && first <= 8, "R6 first pulse", first, 5);

    // R10 one-cycle glitch
    wait_edges(10);
    cpu_stop_n = 1'b0;
    wait_edges(1);
    cpu_stop_n = 1'b1;
    sample_n(40, rc, rm, rp, rf, rx, rr, ha);
    chk(rc == 20, "R10 cpu uninterrupted", rc, 20);
    chk(grp_run == 4'hF, "R10 grp_run", grp_run, 15);

    // R8 / R9 power-down and restart hold
    @(posedge clk); #1 pwr_dn_n = 1'b0;
    wait_edges(16);
    sample_n(16, rc, rm, rp, rf, rx, rr, ha);
    chk(ha == 0, "R8 all low in power-down", ha, 0);
    chk(grp_run == 4'h0, "R8 grp_run", grp_run, 0);
    @(posedge clk); #1 pwr_dn_n = 1'b1;
    late = 0;
    for (int k = 1; k <= RC + 24; k++) begin
      @(negedge clk);
      if (k <= RC + 2 && {cpu_clk, mem_clk, pci_clk, fix_clk} != '0) late++;
    end
    chk(late == 0, "R9 held through restart delay", late, 0);
    chk(grp_run == 4'hF, "R9 running after delay", grp_run, 15);

    // R2 / R3 strap 1, changed after capture
    do_reset(1'b1);
    wait_edges(3);
    mode_strap = 1'b0;
    cpu_stop_n = 1'b0;
    pwr_dn_n   = 1'b0;
    wait_edges(80);
    chk(grp_run == 4'hF, "R2 strap held, pins ignored", grp_run, 15);
    sample_n(32, rc, rm, rp, rf, rx, rr, ha);
    chk(rc == 16, "R3 cpu runs in strap 1", rc, 16);
    chk(rx == 8, "R3 pci_x rate", rx, 8);
    chk(rr == 4, "R3 ref_x rate", rr, 4);

    // R2 strap 0 captured again on next reset
    cpu_stop_n = 1'b1; pwr_dn_n = 1'b1;
    do_reset(1'b0);
    wait_edges(20);
    sample_n(32, rc, rm, rp, rf, rx, rr, ha);
    chk(rx == 0 && rr == 0, "R2 strap 0 recaptured", rx + rr, 0);

    chk(pw_err == 0, "R7 pulse widths", pw_err, 0);
    chk(pw_cnt > 100, "R7 pulses observed", pw_cnt, 101);
    chk(vec_err == 0, "R4 vector and phase match", vec_err, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule